// File: doc/BRIEF.md
# Display Controller Register Block

This block is the software-visible register set of a simple color panel controller. It sits on a 32-bit peripheral bus addressed by word index, inside a 4 KB window of 1024 words. It holds four timing words, two frame base addresses (one for the upper and one for the lower half of a dual panel), a control word, an interrupt mask, a sticky interrupt status with write-one-to-clear, and eight read-only identification bytes at the top of the window.

From these registers it drives the display pipeline directly. The outputs are the panel width and height decoded from packed timing fields, a display-enable, the pixel-depth and byte/pixel ordering controls, the two base addresses, and an interrupt line. A static strap selects the older or the newer register layout. The two layouts differ in where the control and mask words sit and in the identification bytes. A one-cycle resync strobe tells the display side that the geometry or the control word has just changed.

The bus has no back-pressure. A request is taken on every clock edge where `bus_sel` is high. Read data returns one cycle later, qualified by `bus_rvalid`, and the requester must accept it in that cycle.

Top module: `dispc_regif`

## Requirements
- R1: After reset every writable register is zero, so every mapped word other than the identification bytes reads 0, `panel_width` is 16, `panel_height` is 1, and `disp_en` and `irq` are 0.
- R2: `panel_width` equals (timing0[7:2] + 1) * 16, which is the same as ((timing0 & 0xFC) + 4) * 4. `panel_height` equals timing1[9:0] + 1. Timing words 0 to 3 sit at word indices 0 to 3 and read back exactly as written.
- R3: `disp_en` is 1 only when control bit 0 (enable) and control bit 11 (power) are both 1. `ctl_bpp` is control bits [3:1], `ctl_bgr` is bit 8, `ctl_be_byte` is bit 9 and `ctl_be_pix` is bit 10.
- R4: With `variant_new` = 0, control is at word index 6 and the mask at index 7. With `variant_new` = 1, the mask is at index 6 and control at index 7.
- R5: Word indices 0x3F8 to 0x3FF read one identification byte each in bits [7:0]. The older layout gives 10,11,04,00,0D,F0,05,B1 (hex) and the newer layout gives 11,11,24,00,0D,F0,05,B1.
- R6: A 1 on `evt_set[i]` sets status bit i, and the bit stays set. Index 8 reads the raw status and index 9 reads status AND mask. Writing index 10 clears the status bits written as 1. A set wins over a clear of the same bit in the same cycle.
- R7: `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R8: The upper base is at index 4 and the lower base at index 5. Indices 11 and 12 read back the current upper and lower address, which equal those bases. `upper_base` and `lower_base` present the same values.
- R9: `resync` is high for the one cycle that follows a write that changes `panel_width`, `panel_height` or the control word. A write that leaves all three unchanged gives no pulse.
- R10: Reads of unmapped indices return 0. Writes to unmapped indices, or to the read-only indices 8, 9, 11, 12 and the identification bytes, change no register.
- R11: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the read request. A write shows on the outputs in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| variant_new | input | 1 | Layout strap: 0 older, 1 newer |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_widx | input | 10 | Word index in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| evt_set | input | 4 | Interrupt event set pulses |
| panel_width | output | 11 | Decoded width in pixels |
| panel_height | output | 11 | Decoded height in lines |
| disp_en | output | 1 | Display enabled (enable and power) |
| ctl_bpp | output | 3 | Pixel depth code |
| ctl_bgr | output | 1 | Red/blue swap |
| ctl_be_byte | output | 1 | Big-endian byte order |
| ctl_be_pix | output | 1 | Big-endian pixel order |
| upper_base | output | 32 | Upper panel frame base |
| lower_base | output | 32 | Lower panel frame base |
| irq | output | 1 | Interrupt request |
| resync | output | 1 | Geometry or control changed |

## Verification
The bench uses the default parameters: a 10-bit word index, four interrupt sources and 11-bit geometry. The 10-bit index lets the bench reach the identification bytes at the top of the window, and the 11-bit geometry lets it reach both extremes of 16 and 1024. The strap is an input, so the bench resets the block once with each value, and both register layouts and both identification sets are exercised in one run. Four sources leave room for masked and unmasked bits, and for a clear that coincides with a set.

// File: rtl/dispc_regif_pkg.sv
package dispc_regif_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_TIM,
    SEL_UPB,
    SEL_LPB,
    SEL_CTRL,
    SEL_MASK,
    SEL_RAW,
    SEL_MIS,
    SEL_CLR,
    SEL_UPCUR,
    SEL_LPCUR,
    SEL_ID
  } reg_sel_e;

  function automatic logic [7:0] id_byte(input logic newer, input logic [2:0] k);
    case (k)
      3'd0:    id_byte = newer ? 8'h11 : 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = newer ? 8'h24 : 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dispc_addr_dec.sv
module dispc_addr_dec
  import dispc_regif_pkg::*;
#(
  parameter int IDXW = 10
) (
  input  logic [IDXW-1:0] widx,
  input  logic            newer,
  output reg_sel_e        sel,
  output logic [2:0]      sub
);
  localparam int ID_BASE = (1 << IDXW) - 8;

  always_comb begin
    sub = widx[2:0];
    if (widx >= IDXW'(ID_BASE)) begin
      sel = SEL_ID;
    end else begin
      case (widx)
        IDXW'(0), IDXW'(1), IDXW'(2), IDXW'(3): sel = SEL_TIM;
        IDXW'(4):  sel = SEL_UPB;
        IDXW'(5):  sel = SEL_LPB;
        IDXW'(6):  sel = newer ? SEL_MASK : SEL_CTRL;
        IDXW'(7):  sel = newer ? SEL_CTRL : SEL_MASK;
        IDXW'(8):  sel = SEL_RAW;
        IDXW'(9):  sel = SEL_MIS;
        IDXW'(10): sel = SEL_CLR;
        IDXW'(11): sel = SEL_UPCUR;
        IDXW'(12): sel = SEL_LPCUR;
        default:   sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dispc_irq_ctl.sv
module dispc_irq_ctl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] evt_set,
  output logic [N-1:0] mask,
  output logic [N-1:0] status,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '0;
      status <= '0;
    end else begin
      if (mask_we) mask <= wdata;
      status <= (status & ~(clr_we ? wdata : '0)) | evt_set;
    end
  end

  assign irq = |(status & mask);

  // R6: a set bit stays set on the following cycle
  a_r6_set_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((status & $past(evt_set)) == $past(evt_set)));

  // R6: clearing with no coincident event empties the written bits
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && evt_set == '0) |=> ((status & $past(wdata)) == '0));
endmodule

// File: rtl/dispc_geom.sv
module dispc_geom #(
  parameter int GW = 11,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    hfield,
  input  logic [9:0]    vfield,
  input  logic [CW-1:0] ctrl,
  output logic [GW-1:0] width,
  output logic [GW-1:0] height,
  output logic          resync
);
  localparam logic [GW-1:0] RST_W = GW'(16);
  localparam logic [GW-1:0] RST_H = GW'(1);

  logic [GW-1:0] prev_w, prev_h;
  logic [CW-1:0] prev_c;

  assign width  = (GW'(hfield) + GW'(1)) << 4;
  assign height = GW'(vfield) + GW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_w <= RST_W;
      prev_h <= RST_H;
      prev_c <= '0;
    end else begin
      prev_w <= width;
      prev_h <= height;
      prev_c <= ctrl;
    end
  end

  assign resync = (width != prev_w) || (height != prev_h) || (ctrl != prev_c);

  // R9: a strobe only when some watched value moved since the last cycle
  a_r9_resync_cause: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> !($stable(width) && $stable(height) && $stable(ctrl)));
endmodule

// File: rtl/dispc_regif.sv
module dispc_regif
  import dispc_regif_pkg::*;
#(
  parameter int IDXW  = 10,
  parameter int DW    = 32,
  parameter int IRQ_N = 4,
  parameter int GW    = 11,
  parameter int NTIM  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             variant_new,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [IDXW-1:0]  bus_widx,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rvalid,
  input  logic [IRQ_N-1:0] evt_set,
  output logic [GW-1:0]    panel_width,
  output logic [GW-1:0]    panel_height,
  output logic             disp_en,
  output logic [2:0]       ctl_bpp,
  output logic             ctl_bgr,
  output logic             ctl_be_byte,
  output logic             ctl_be_pix,
  output logic [DW-1:0]    upper_base,
  output logic [DW-1:0]    lower_base,
  output logic             irq,
  output logic             resync
);
  localparam int TSW = $clog2(NTIM);

  reg_sel_e         sel;
  logic [2:0]       sub;
  logic             wr_go, rd_go;
  logic [DW-1:0]    tim_q [NTIM];
  logic [DW-1:0]    upb_q, lpb_q, ctrl_q;
  logic [IRQ_N-1:0] mask_q, status_q;
  logic [DW-1:0]    rd_n;

  assign wr_go = bus_sel && bus_wr;
  assign rd_go = bus_sel && !bus_wr;

  dispc_addr_dec #(.IDXW(IDXW)) dec_i (
    .widx  (bus_widx),
    .newer (variant_new),
    .sel   (sel),
    .sub   (sub)
  );

  for (genvar g = 0; g < NTIM; g++) begin : g_tim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tim_q[g] <= '0;
      else if (wr_go && sel == SEL_TIM && sub[TSW-1:0] == TSW'(g))
        tim_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upb_q  <= '0;
      lpb_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_go) begin
      case (sel)
        SEL_UPB:  upb_q  <= bus_wdata;
        SEL_LPB:  lpb_q  <= bus_wdata;
        SEL_CTRL: ctrl_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  dispc_irq_ctl #(.N(IRQ_N)) irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (wr_go && sel == SEL_MASK),
    .clr_we  (wr_go && sel == SEL_CLR),
    .wdata   (bus_wdata[IRQ_N-1:0]),
    .evt_set (evt_set),
    .mask    (mask_q),
    .status  (status_q),
    .irq     (irq)
  );

  dispc_geom #(.GW(GW), .CW(DW)) geom_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .hfield (tim_q[0][7:2]),
    .vfield (tim_q[1][9:0]),
    .ctrl   (ctrl_q),
    .width  (panel_width),
    .height (panel_height),
    .resync (resync)
  );

  always_comb begin
    rd_n = '0;
    case (sel)
      SEL_TIM:            rd_n = tim_q[sub[TSW-1:0]];
      SEL_UPB, SEL_UPCUR: rd_n = upb_q;
      SEL_LPB, SEL_LPCUR: rd_n = lpb_q;
      SEL_CTRL:           rd_n = ctrl_q;
      SEL_MASK:           rd_n[IRQ_N-1:0] = mask_q;
      SEL_RAW:            rd_n[IRQ_N-1:0] = status_q;
      SEL_MIS:            rd_n[IRQ_N-1:0] = status_q & mask_q;
      SEL_ID:             rd_n[7:0] = id_byte(variant_new, sub);
      default:            rd_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_go;
      if (rd_go) bus_rdata <= rd_n;
    end
  end

  assign disp_en     = ctrl_q[0] && ctrl_q[11];
  assign ctl_bpp     = ctrl_q[3:1];
  assign ctl_bgr     = ctrl_q[8];
  assign ctl_be_byte = ctrl_q[9];
  assign ctl_be_pix  = ctrl_q[10];
  assign upper_base  = upb_q;
  assign lower_base  = lpb_q;

  // R11: every read request is answered on the next cycle
  a_r11_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> bus_rvalid);

  // R11: no read data without a request one cycle earlier
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(rd_go));

  // R10: a write that hits no writable register leaves state untouched
  a_r10_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && sel inside {SEL_NONE, SEL_RAW, SEL_MIS, SEL_UPCUR, SEL_LPCUR, SEL_ID})
    |=> $stable({tim_q[0], upb_q, lpb_q, ctrl_q, mask_q}));
endmodule

// File: tb/dispc_regif_tb_top.sv
module dispc_regif_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        variant_new = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_widx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  evt_set = '0;
  logic [10:0] panel_width, panel_height;
  logic        disp_en, ctl_bgr, ctl_be_byte, ctl_be_pix, irq, resync;
  logic [2:0]  ctl_bpp;
  logic [31:0] upper_base, lower_base;

  int checks = 0;
  int errors = 0;
  logic last_resync;

  always #5 clk = ~clk;

  dispc_regif dut_i (
    .clk(clk), .rst_n(rst_n), .variant_new(variant_new),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_widx(bus_widx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .evt_set(evt_set), .panel_width(panel_width), .panel_height(panel_height),
    .disp_en(disp_en), .ctl_bpp(ctl_bpp), .ctl_bgr(ctl_bgr),
    .ctl_be_byte(ctl_be_byte), .ctl_be_pix(ctl_be_pix),
    .upper_base(upper_base), .lower_base(lower_base), .irq(irq), .resync(resync)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic newer);
    @(negedge clk);
    rst_n = 1'b0;
    variant_new = newer;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_widx = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    last_resync = resync;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_widx = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
    check("R11 rvalid", 32'(bus_rvalid), 32'd1);
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset(input logic newer);
    do_reset(newer);
    check("R1 width", 32'(panel_width), 32'd16);
    check("R1 height", 32'(panel_height), 32'd1);
    check("R1 disp_en", 32'(disp_en), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 resync", 32'(resync), 32'd0);
    for (int i = 0; i < 13; i++) rd_chk("R1 regs zero", 10'(i), 32'd0);
  endtask

  task automatic t_geometry();
    wr(10'd0, 32'h13);
    check("R2 width 80", 32'(panel_width), 32'd80);
    check("R9 pulse width", 32'(last_resync), 32'd1);
    @(negedge clk);
    check("R9 single cycle", 32'(resync), 32'd0);
    wr(10'd0, 32'hABCDEF13);
    check("R9 no pulse same width", 32'(last_resync), 32'd0);
    rd_chk("R2 timing0 readback", 10'd0, 32'hABCDEF13);
    wr(10'd0, 32'hFC);
    check("R2 width 1024", 32'(panel_width), 32'd1024);
    wr(10'd0, 32'h0);
    check("R2 width 16", 32'(panel_width), 32'd16);
    wr(10'd1, 32'h1DF);
    check("R2 height 480", 32'(panel_height), 32'd480);
    check("R9 pulse height", 32'(last_resync), 32'd1);
    wr(10'd1, 32'h3FF);
    check("R2 height 1024", 32'(panel_height), 32'd1024);
    wr(10'd1, 32'hFFFFFC00);
    check("R2 height 1", 32'(panel_height), 32'd1);
    wr(10'd1, 32'hFFFFFC00);
    check("R9 no pulse rewrite", 32'(last_resync), 32'd0);
    wr(10'd2, 32'h5A5A1234);
    wr(10'd3, 32'h00C0FFEE);
    check("R9 no pulse timing2/3", 32'(last_resync), 32'd0);
    rd_chk("R2 timing2", 10'd2, 32'h5A5A1234);
    rd_chk("R2 timing3", 10'd3, 32'h00C0FFEE);
  endtask

  task automatic t_control(input logic newer);
    logic [9:0] ci, mi;
    ci = newer ? 10'd7 : 10'd6;
    mi = newer ? 10'd6 : 10'd7;
    wr(ci, 32'h001);
    check("R3 enable alone", 32'(disp_en), 32'd0);
    check("R9 pulse ctrl", 32'(last_resync), 32'd1);
    wr(ci, 32'h800);
    check("R3 power alone", 32'(disp_en), 32'd0);
    wr(ci, 32'h801);
    check("R3 both", 32'(disp_en), 32'd1);
    wr(ci, 32'h801);
    check("R9 no pulse ctrl same", 32'(last_resync), 32'd0);
    wr(ci, 32'hF0B);
    check("R3 bpp", 32'(ctl_bpp), 32'd5);
    check("R3 bgr", 32'(ctl_bgr), 32'd1);
    check("R3 be_byte", 32'(ctl_be_byte), 32'd1);
    check("R3 be_pix", 32'(ctl_be_pix), 32'd1);
    check("R3 enabled", 32'(disp_en), 32'd1);
    rd_chk("R4 ctrl slot", ci, 32'hF0B);
    wr(mi, 32'h5);
    rd_chk("R4 mask slot", mi, 32'h5);
    check("R4 mask not ctrl", 32'(disp_en), 32'd1);
  endtask

  task automatic pulse(input logic [3:0] ev, input logic do_clr, input logic [3:0] cv);
    @(negedge clk);
    evt_set = ev;
    if (do_clr) begin
      bus_sel = 1'b1; bus_wr = 1'b1; bus_widx = 10'd10; bus_wdata = 32'(cv);
    end
    @(negedge clk);
    evt_set = '0; bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic t_irq();
    pulse(4'hA, 1'b0, 4'h0);
    check("R7 masked off", 32'(irq), 32'd0);
    rd_chk("R6 raw", 10'd8, 32'hA);
    rd_chk("R6 masked", 10'd9, 32'h0);
    pulse(4'h1, 1'b0, 4'h0);
    check("R7 irq on", 32'(irq), 32'd1);
    rd_chk("R6 raw sticky", 10'd8, 32'hB);
    rd_chk("R6 masked 1", 10'd9, 32'h1);
    wr(10'd10, 32'h1);
    check("R7 irq off", 32'(irq), 32'd0);
    rd_chk("R6 after clear", 10'd8, 32'hA);
    pulse(4'h4, 1'b1, 4'h4);
    rd_chk("R6 set wins", 10'd8, 32'hE);
    check("R7 irq set wins", 32'(irq), 32'd1);
    wr(10'd10, 32'hF);
    rd_chk("R6 clear all", 10'd8, 32'h0);
    check("R7 irq cleared", 32'(irq), 32'd0);
  endtask

  task automatic t_ids(input logic newer);
    logic [7:0] exp [8];
    exp = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (newer) begin
      exp[0] = 8'h11;
      exp[2] = 8'h24;
    end
    for (int k = 0; k < 8; k++) rd_chk("R5 id byte", 10'(10'h3F8 + k), 32'(exp[k]));
  endtask

  task automatic t_bases();
    wr(10'd4, 32'h1000_0000);
    wr(10'd5, 32'h2000_4000);
    rd_chk("R8 upper", 10'd4, 32'h1000_0000);
    rd_chk("R8 lower", 10'd5, 32'h2000_4000);
    rd_chk("R8 upper current", 10'd11, 32'h1000_0000);
    rd_chk("R8 lower current", 10'd12, 32'h2000_4000);
    check("R8 upper port", upper_base, 32'h1000_0000);
    check("R8 lower port", lower_base, 32'h2000_4000);
  endtask

  task automatic t_unmapped();
    wr(10'd13, 32'hFFFF_FFFF);
    wr(10'h080, 32'hFFFF_FFFF);
    wr(10'h3F7, 32'hFFFF_FFFF);
    wr(10'd11, 32'hFFFF_FFFF);
    wr(10'd8, 32'hFFFF_FFFF);
    wr(10'h3FA, 32'hFFFF_FFFF);
    rd_chk("R10 read idx13", 10'd13, 32'd0);
    rd_chk("R10 read 0x80", 10'h080, 32'd0);
    rd_chk("R10 read 0x3F7", 10'h3F7, 32'd0);
    rd_chk("R10 base kept", 10'd4, 32'h1000_0000);
    rd_chk("R10 raw kept", 10'd8, 32'h0);
    rd_chk("R10 timing0 kept", 10'd0, 32'h0);
    check("R10 width kept", 32'(panel_width), 32'd16);
    check("R10 irq kept", 32'(irq), 32'd0);
  endtask

  initial begin
    t_reset(1'b0);
    t_geometry();
    t_control(1'b0);
    t_irq();
    t_ids(1'b0);
    t_bases();
    t_unmapped();
    t_reset(1'b1);
    t_control(1'b1);
    t_irq();
    t_ids(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule